// File: doc/BRIEF.md
# Peripheral Bus Command Controller

This block sits between a 32-bit processor and a 16-bit peripheral bus. It watches the processor's address strobe and its three status lines. When the separate cycle tracker signals a bus-cycle start, the block claims three kinds of cycle: I/O reads, I/O writes and boot-ROM reads. Every other cycle is left to other subsystems. All logic runs on the double-frequency processor clock, so the strobe and status lines are sampled directly.

Two state machines cooperate. The cycle machine classifies the claimed cycle and drives the read or write command strobe. It requests a start pulse from an external wait-state timer and then holds the command until that timer reports that its delay is done. It then returns ready for one processor clock, which is two bus-clock cycles, and goes idle. The transceiver machine first sets the data transceiver direction from the cycle type. One cycle later it enables the transceivers, and it keeps them enabled until the bus cycle ends. Every claimed cycle reports a 16-bit bus size, so the processor never pipelines these cycles.

Top module: `pbus_cmd_ctrl`

## Requirements
- R1: While reset is low, and in the cycle after it, xcvr_en, rd_cmd, wr_cmd, tmr_start, rdy and bus16 are 0, and xcvr_to_cpu is 1.
- R2: A cycle is claimed at a clock edge where cyc_start=1 and ads_n=0 and the status decodes as follows. I/O read is mio=0, dc=1, wr=0. I/O write is mio=0, dc=1, wr=1. ROM read is mio=1, dc=1, wr=0, rom_sel=1.
- R3: Any other combination of ads_n, cyc_start, mio, dc, wr and rom_sel at an idle edge leaves every output unchanged. Outputs stay in the idle values of R1, and xcvr_to_cpu keeps its last value.
- R4: From the cycle after the claiming edge, rd_cmd=1 for I/O and ROM reads and wr_cmd=1 for I/O writes. The two are never high together.
- R5: tmr_start is high for exactly one cycle, the cycle after the claiming edge.
- R6: While dly_done is sampled low, the command stays asserted and rdy stays low, for any number of cycles.
- R7: After the edge where dly_done is sampled high, rdy is high for exactly two cycles. In the following cycle rdy, the command, bus16 and xcvr_en are all low.
- R8: bus16 is high from the cycle after the claiming edge through the last rdy cycle.
- R9: xcvr_to_cpu is 1 for reads and 0 for writes from the cycle after the claiming edge. xcvr_en rises one cycle later and falls together with rdy.
- R10: A cycle-start indication that arrives while a cycle is in progress is ignored. The command type and the timing of that cycle do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-frequency processor bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ads_n | input | 1 | Processor address strobe, active low |
| mio | input | 1 | Status: 1 = memory, 0 = I/O |
| dc | input | 1 | Status: 1 = data, 0 = control |
| wr | input | 1 | Status: 1 = write, 0 = read |
| rom_sel | input | 1 | Address decode hit on the boot ROM |
| cyc_start | input | 1 | Bus-cycle start from the cycle tracker |
| dly_done | input | 1 | Wait-state timer delay expired |
| xcvr_en | output | 1 | Data transceiver enable |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 = toward processor |
| rd_cmd | output | 1 | Peripheral read command |
| wr_cmd | output | 1 | Peripheral write command |
| tmr_start | output | 1 | Start request to the wait-state timer |
| bus16 | output | 1 | 16-bit bus size indication |
| rdy | output | 1 | Ready returned to the processor |

## Verification
The hardest situation to reach is a fresh, valid cycle-start indication arriving while a command is still being held for the timer. It must not retype the cycle, restart the timer or change the transceiver direction. To reach it, the bench sweeps all 64 combinations of strobe, start and status lines with several delay lengths. During every hold cycle it drives a valid claim of the opposite direction. It then checks that the command, direction and timer request stay as they were.

// File: rtl/pbus_pkg.sv
// Shared types for the peripheral bus command controller.
package pbus_pkg;
    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_IO_RD  = 2'd1,
        KIND_IO_WR  = 2'd2,
        KIND_ROM_RD = 2'd3
    } cyc_kind_t;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_CMD  = 2'd1,
        CS_RDY  = 2'd2
    } cyc_state_t;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_SETUP = 2'd1,
        XS_ON    = 2'd2
    } xcvr_state_t;
endpackage

// File: rtl/pbus_decode.sv
// Classifies the processor status into a claimable cycle kind.
// Assumes status lines are valid whenever the address strobe is low.
module pbus_decode
    import pbus_pkg::*;
(
    input  logic      ads_n,
    input  logic      cyc_start,
    input  logic      mio,
    input  logic      dc,
    input  logic      wr,
    input  logic      rom_sel,
    output cyc_kind_t kind,
    output logic      claim
);
    // Decode status into a kind; unowned combinations map to none.
    always_comb begin
        kind = KIND_NONE;
        if (dc) begin
            if (!mio && !wr)               kind = KIND_IO_RD;
            else if (!mio && wr)           kind = KIND_IO_WR;
            else if (mio && !wr && rom_sel) kind = KIND_ROM_RD;
        end
    end

    // A claim needs a strobed cycle start and an owned kind.
    assign claim = cyc_start && !ads_n && (kind != KIND_NONE);
endmodule

// File: rtl/pbus_cyc_fsm.sv
// Cycle machine: latches the claimed kind, drives the command strobe,
// pulses the timer start, waits for delay-done, then returns ready
// for RDY_CYCLES bus clocks. Assumes dly_done comes from the timer
// that tmr_start launched.
module pbus_cyc_fsm
    import pbus_pkg::*;
#(
    parameter int RDY_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      claim,
    input  cyc_kind_t kind_in,
    input  logic      dly_done,
    output logic      rd_cmd,
    output logic      wr_cmd,
    output logic      tmr_start,
    output logic      rdy,
    output logic      busy,
    output logic      done
);
    localparam int CW = (RDY_CYCLES > 1) ? $clog2(RDY_CYCLES) : 1;

    cyc_state_t    state;
    cyc_kind_t     kind;
    logic [CW-1:0] cnt;
    logic          tmr_q;

    // Sequence IDLE -> CMD -> RDY -> IDLE, latching kind on claim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_IDLE;
            kind  <= KIND_NONE;
            cnt   <= '0;
            tmr_q <= 1'b0;
        end else begin
            tmr_q <= 1'b0;
            case (state)
                CS_IDLE: if (claim) begin
                    state <= CS_CMD;
                    kind  <= kind_in;
                    tmr_q <= 1'b1;
                end
                CS_CMD: if (dly_done) begin
                    state <= CS_RDY;
                    cnt   <= CW'(RDY_CYCLES - 1);
                end
                CS_RDY: begin
                    if (cnt == '0) begin
                        state <= CS_IDLE;
                        kind  <= KIND_NONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state registers.
    assign busy      = (state != CS_IDLE);
    assign rd_cmd    = busy && (kind == KIND_IO_RD || kind == KIND_ROM_RD);
    assign wr_cmd    = busy && (kind == KIND_IO_WR);
    assign rdy       = (state == CS_RDY);
    assign done      = (state == CS_RDY) && (cnt == '0);
    assign tmr_start = tmr_q;

    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_cmd && wr_cmd)); // R4
    AST_TMR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> !tmr_start); // R5
    AST_HOLD_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_cmd || wr_cmd) && !rdy && !dly_done) |=> (!rdy && (rd_cmd || wr_cmd))); // R6
    AST_RDY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> (!rd_cmd && !wr_cmd)); // R7
endmodule

// File: rtl/pbus_xcvr_fsm.sv
// Transceiver machine: sets direction on claim, enables the
// transceivers one cycle later and holds them until the cycle ends.
// Assumes done is a single-cycle end marker from the cycle machine.
module pbus_xcvr_fsm
    import pbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim,
    input  logic claim_is_rd,
    input  logic done,
    output logic xcvr_en,
    output logic xcvr_to_cpu
);
    xcvr_state_t state;
    logic        dir_q;

    // Direction first, then enable, then release at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XS_IDLE;
            dir_q <= 1'b1;
        end else begin
            case (state)
                XS_IDLE: if (claim) begin
                    dir_q <= claim_is_rd;
                    state <= XS_SETUP;
                end
                XS_SETUP: state <= XS_ON;
                XS_ON:    if (done) state <= XS_IDLE;
                default:  state <= XS_IDLE;
            endcase
        end
    end

    assign xcvr_en     = (state == XS_ON);
    assign xcvr_to_cpu = dir_q;

    AST_DIR_BEFORE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xcvr_en) |-> $stable(xcvr_to_cpu)); // R9
endmodule

// File: rtl/pbus_cmd_ctrl.sv
// Top: peripheral bus command controller. Claims I/O and boot-ROM
// cycles, forces them to 16-bit width and paces them with an
// external wait-state timer. Assumes all inputs are synchronous
// to clk.
module pbus_cmd_ctrl
    import pbus_pkg::*;
#(
    parameter int RDY_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ads_n,
    input  logic mio,
    input  logic dc,
    input  logic wr,
    input  logic rom_sel,
    input  logic cyc_start,
    input  logic dly_done,
    output logic xcvr_en,
    output logic xcvr_to_cpu,
    output logic rd_cmd,
    output logic wr_cmd,
    output logic tmr_start,
    output logic bus16,
    output logic rdy
);
    cyc_kind_t kind;
    logic      claim_raw;
    logic      claim;
    logic      busy;
    logic      done;

    pbus_decode u_decode (
        .ads_n     (ads_n),
        .cyc_start (cyc_start),
        .mio       (mio),
        .dc        (dc),
        .wr        (wr),
        .rom_sel   (rom_sel),
        .kind      (kind),
        .claim     (claim_raw)
    );

    // Only an idle controller may take a new cycle.
    assign claim = claim_raw && !busy;

    pbus_cyc_fsm #(.RDY_CYCLES(RDY_CYCLES)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (claim),
        .kind_in   (kind),
        .dly_done  (dly_done),
        .rd_cmd    (rd_cmd),
        .wr_cmd    (wr_cmd),
        .tmr_start (tmr_start),
        .rdy       (rdy),
        .busy      (busy),
        .done      (done)
    );

    pbus_xcvr_fsm u_xcvr (
        .clk         (clk),
        .rst_n       (rst_n),
        .claim       (claim),
        .claim_is_rd (kind != KIND_IO_WR),
        .done        (done),
        .xcvr_en     (xcvr_en),
        .xcvr_to_cpu (xcvr_to_cpu)
    );

    assign bus16 = busy;

    AST_EN_WITHIN_BUS16: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_en |-> bus16); // R8
    AST_NO_RETYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !rdy) |=> (rdy || rd_cmd)); // R10
endmodule

// File: tb/test_pbus_cmd_ctrl.sv
module test_pbus_cmd_ctrl;
    logic clk = 1'b0;
    logic rst_n, ads_n, mio, dc, wr, rom_sel, cyc_start, dly_done;
    logic xcvr_en, xcvr_to_cpu, rd_cmd, wr_cmd, tmr_start, bus16, rdy;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic last_dir;

    always #2 clk = ~clk;

    pbus_cmd_ctrl i_pbus_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
        .rom_sel(rom_sel), .cyc_start(cyc_start), .dly_done(dly_done),
        .xcvr_en(xcvr_en), .xcvr_to_cpu(xcvr_to_cpu), .rd_cmd(rd_cmd),
        .wr_cmd(wr_cmd), .tmr_start(tmr_start), .bus16(bus16), .rdy(rdy)
    );

    // Packs {en,dir,rd,wr,tmr,b16,rdy} for compact comparison.
    function automatic logic [6:0] pack();
        return {xcvr_en, xcvr_to_cpu, rd_cmd, wr_cmd, tmr_start, bus16, rdy};
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        n_chk++;
        if (pack() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (en,dir,rd,wr,tmr,b16,rdy) t=%0t",
                     req, pack(), exp, $time);
        end
    endtask

    task automatic idle_inputs();
        ads_n = 1; cyc_start = 0; mio = 0; dc = 0; wr = 0; rom_sel = 0; dly_done = 0;
    endtask

    // One sweep point: combination c, hold length d.
    task automatic run(input int c, input int d);
        logic a, s, m, dd, w, r, claimed, is_wr, is_rd;
        {a, s, m, dd, w, r} = c[5:0];
        is_wr = !m && dd && w;
        is_rd = dd && !w && (!m || r);
        claimed = !a && s && (is_wr || is_rd);
        @(negedge clk);
        ads_n = a; cyc_start = s; mio = m; dc = dd; wr = w; rom_sel = r; dly_done = 0;
        @(negedge clk);
        idle_inputs();
        if (!claimed) begin
            check("R3", {1'b0, last_dir, 5'b0});
            return;
        end
        // R2 R4 R5 R8 R9: first cycle after claim
        check("R2/R4/R5/R8/R9", {1'b0, is_rd, is_rd, is_wr, 1'b1, 1'b1, 1'b0});
        last_dir = is_rd;
        for (int i = 0; i < d; i++) begin
            // R10: opposite-direction claim attempt while busy
            ads_n = 0; cyc_start = 1; mio = 0; dc = 1; wr = is_rd; rom_sel = 0;
            @(negedge clk);
            check("R6/R10", {1'b1, is_rd, is_rd, is_wr, 1'b0, 1'b1, 1'b0});
        end
        idle_inputs();
        dly_done = 1;
        @(negedge clk);
        dly_done = 0;
        check("R7", {1'b1, is_rd, is_rd, is_wr, 1'b0, 1'b1, 1'b1});
        @(negedge clk);
        check("R7", {1'b1, is_rd, is_rd, is_wr, 1'b0, 1'b1, 1'b1});
        @(negedge clk);
        check("R7/R8/R9 end", {1'b0, is_rd, 5'b0});
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        last_dir = 1;
        repeat (3) @(negedge clk);
        check("R1 in reset", 7'b0100000);
        // R1: reset dominates a valid claim
        ads_n = 0; cyc_start = 1; dc = 1;
        @(negedge clk);
        check("R1 claim in reset", 7'b0100000);
        idle_inputs();
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset", 7'b0100000);
        for (int d = 0; d < 4; d++)
            for (int c = 0; c < 64; c++)
                run(c, (c + d) % 5);
        // Long hold, R6
        run(6'b010100, 40);
        // Reset mid-cycle returns to idle, R1
        @(negedge clk);
        ads_n = 0; cyc_start = 1; mio = 0; dc = 1; wr = 1; rom_sel = 0;
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        check("R1 mid-cycle reset", 7'b0100000);
        rst_n = 1;
        @(negedge clk);
        check("R1 released", 7'b0100000);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule